// File: doc/BRIEF.md
# Overcurrent Fault Handler with Retry

This block sits between three per-phase overcurrent comparators and the gate-drive enable of a three-phase output stage. Each comparator output is filtered on its own. A detection is accepted only when the comparator has stayed high for a programmable number of clock cycles. A 2-bit filter code selects one of four lengths, nominally 0.3 µs, 0.6 µs, 1.25 µs and 1.6 µs.

An accepted detection is handled according to a 2-bit response code:

- **Latch:** the outputs are shut off until a clear arrives.
- **Retry:** the outputs are shut off for a fixed recovery interval, then re-enabled. The interval is nominally 5 ms or 500 ms, selected by one input bit.
- **Report:** the fault is flagged and the outputs keep running.
- **Ignore:** the detection is dropped completely.

A sticky status bit per phase records which comparator fired. An active-low flag summarises the status bits. A one-cycle clear input resets the status bits and releases any shutdown.

All filter lengths and both retry intervals are parameters expressed in clock cycles. The defaults match a 200 MHz clock.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: A phase detection is accepted only after `oc_raw[i]` has been sampled high on N consecutive clock edges. N is DG0_CYC, DG1_CYC, DG2_CYC or DG3_CYC for `dg_sel` = 00, 01, 10 or 11. The resulting `drv_off` and `phase_flag` change is visible after edge N+1.
- R2: If `oc_raw[i]` is sampled low before N consecutive high samples, the filter restarts from zero, and no fault results from high runs shorter than N.
- R3: With `resp_mode` = 00 (latch), an accepted detection sets `drv_off`. It stays high, for any length of time, until `clear` is pulsed.
- R4: With `resp_mode` = 01 (retry) and `retry_long` = 0, `drv_off` is high for exactly RETRY_SHORT_CYC cycles after an accepted detection, then returns low by itself.
- R5: With `resp_mode` = 01 and `retry_long` = 1, `drv_off` is high for exactly RETRY_LONG_CYC cycles.
- R6: With `resp_mode` = 10 (report), an accepted detection sets the status bit and pulls `fault_n` low, while `drv_off` stays low.
- R7: With `resp_mode` = 11 (ignore), detections change neither `phase_flag`, `drv_off` nor `fault_n`.
- R8: `phase_flag[i]` is set by an accepted detection on phase i. It remains set after a retry re-enables the outputs, and only `clear` resets it. Several phases may be flagged at once.
- R9: `fault_n` is 0 exactly when at least one `phase_flag` bit is set.
- R10: A `clear` pulse makes `phase_flag` zero and `drv_off` low on the next cycle. It takes priority over a detection accepted on the same edge.
- R11: After reset, `drv_off` = 0, `phase_flag` = 000 and `fault_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 3 | Raw comparator outputs, bit i = phase i |
| resp_mode | input | 2 | Response: 00 latch, 01 retry, 10 report, 11 ignore |
| dg_sel | input | 2 | Deglitch length select |
| retry_long | input | 1 | Retry interval select: 0 short, 1 long |
| clear | input | 1 | One-cycle fault clear |
| drv_off | output | 1 | High disables the output stage |
| phase_flag | output | 3 | Sticky per-phase fault status |
| fault_n | output | 1 | Active-low summary fault flag |

## Verification
The hardest conditions to reach from the ports are two exact timing cases. The first is the retry window: `drv_off` must be high for exactly the configured number of cycles. The bench drives a detection that is accepted and then removed well before expiry, and counts the high samples one by one for both interval selections. The second is the filter boundary. A run of N-1 high samples, a single low sample, and another N-1 high samples must produce nothing. The bench also checks the cycle on which a run of exactly N samples takes effect. A clear that arrives while a comparator is still held high is used to show that clear wins on that edge and that the flag returns on the following one.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        RESP_LATCH  = 2'b00,
        RESP_RETRY  = 2'b01,
        RESP_REPORT = 2'b10,
        RESP_IGNORE = 2'b11
    } resp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_HOLD = 2'b01,
        ST_WAIT = 2'b10
    } ctl_state_e;

    localparam int unsigned NUM_PHASES = 3;

endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
    parameter int unsigned DG0_CYC = 60,
    parameter int unsigned DG1_CYC = 120,
    parameter int unsigned DG2_CYC = 250,
    parameter int unsigned DG3_CYC = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  logic [1:0] dg_sel,
    output logic       det
);
    localparam int unsigned MAX01 = (DG0_CYC > DG1_CYC) ? DG0_CYC : DG1_CYC;
    localparam int unsigned MAX23 = (DG2_CYC > DG3_CYC) ? DG2_CYC : DG3_CYC;
    localparam int unsigned MAXN  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CW    = $clog2(MAXN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          det;
    } dg_reg_t;

    dg_reg_t       r_q, r_d;
    logic [CW-1:0] lim_m1;

    always_comb begin
        unique case (dg_sel)
            2'b00:   lim_m1 = CW'(DG0_CYC - 1);
            2'b01:   lim_m1 = CW'(DG1_CYC - 1);
            2'b10:   lim_m1 = CW'(DG2_CYC - 1);
            default: lim_m1 = CW'(DG3_CYC - 1);
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (!raw) begin
            r_d.cnt = '0;
            r_d.det = 1'b0;
        end else begin
            r_d.det = (r_q.cnt >= lim_m1);
            if (r_q.cnt < lim_m1) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign det = r_q.det;

    // R1: an accepted detection always follows a high raw sample
    a_r1_det_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> $past(raw));

    // R2: a low sample drops acceptance and restarts the filter
    a_r2_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> (!det && r_q.cnt == '0));

endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
    parameter int unsigned SHORT_CYC = 1_000_000,
    parameter int unsigned LONG_CYC  = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic expire
);
    localparam int unsigned MAXT = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int unsigned TW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          run;
    } tm_reg_t;

    tm_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.cnt = long_sel ? TW'(LONG_CYC - 1) : TW'(SHORT_CYC - 1);
            r_d.run = 1'b1;
        end else if (r_q.run) begin
            if (r_q.cnt == '0) begin
                r_d.run = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expire = r_q.run && (r_q.cnt == '0);

    // R4: the running countdown steps by exactly one each cycle
    a_r4_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.run && !start && r_q.cnt != '0) |=> (r_q.run && r_q.cnt == $past(r_q.cnt) - 1'b1));

    // R5: a long start loads the long interval
    a_r5_long_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && long_sel) |=> (r_q.cnt == TW'(LONG_CYC - 1)));

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int unsigned DG0_CYC         = 60,
    parameter int unsigned DG1_CYC         = 120,
    parameter int unsigned DG2_CYC         = 250,
    parameter int unsigned DG3_CYC         = 320,
    parameter int unsigned RETRY_SHORT_CYC = 1_000_000,
    parameter int unsigned RETRY_LONG_CYC  = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] oc_raw,
    input  logic [1:0] resp_mode,
    input  logic [1:0] dg_sel,
    input  logic       retry_long,
    input  logic       clear,
    output logic       drv_off,
    output logic [2:0] phase_flag,
    output logic       fault_n
);
    localparam int unsigned NP = NUM_PHASES;

    typedef struct packed {
        ctl_state_e    state;
        logic [NP-1:0] flag;
    } ctl_reg_t;

    ctl_reg_t      r_q, r_d;
    logic [NP-1:0] det;
    logic [NP-1:0] qual;
    logic          any_hit;
    logic          tmr_start;
    logic          tmr_expire;
    resp_mode_e    mode;

    assign mode = resp_mode_e'(resp_mode);

    for (genvar p = 0; p < NP; p++) begin : g_phase
        ocp_deglitch #(
            .DG0_CYC(DG0_CYC),
            .DG1_CYC(DG1_CYC),
            .DG2_CYC(DG2_CYC),
            .DG3_CYC(DG3_CYC)
        ) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (oc_raw[p]),
            .dg_sel(dg_sel),
            .det   (det[p])
        );
    end

    ocp_retry_timer #(
        .SHORT_CYC(RETRY_SHORT_CYC),
        .LONG_CYC (RETRY_LONG_CYC)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .long_sel(retry_long),
        .expire  (tmr_expire)
    );

    assign qual      = (mode == RESP_IGNORE) ? '0 : det;
    assign any_hit   = |qual;
    assign tmr_start = !clear && (r_q.state == ST_RUN) && any_hit && (mode == RESP_RETRY);

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.flag  = '0;
            r_d.state = ST_RUN;
        end else begin
            r_d.flag = r_q.flag | qual;
            unique case (r_q.state)
                ST_RUN: begin
                    if (any_hit && mode == RESP_LATCH) begin
                        r_d.state = ST_HOLD;
                    end else if (any_hit && mode == RESP_RETRY) begin
                        r_d.state = ST_WAIT;
                    end
                end
                ST_HOLD: r_d.state = ST_HOLD;
                ST_WAIT: begin
                    if (tmr_expire) begin
                        r_d.state = ST_RUN;
                    end
                end
                default: r_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, flag: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_off    = (r_q.state != ST_RUN);
    assign phase_flag = r_q.flag;
    assign fault_n    = ~|r_q.flag;

    // R3: a latched shutdown persists until clear
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && !clear) |=> drv_off);

    // R6: report mode never shuts the outputs from a running state
    a_r6_report_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RESP_REPORT && r_q.state == ST_RUN) |=> !drv_off);

    // R7: ignore mode leaves the status unchanged
    a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RESP_IGNORE && !clear) |=> $stable(phase_flag));

    // R8: status bits only fall through a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && |phase_flag) |=> ((phase_flag & $past(phase_flag)) == $past(phase_flag)));

    // R9: a shutdown always comes with the fault flag
    a_r9_off_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_off) |-> !fault_n);

    // R10: clear wins over everything on its edge
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!drv_off && phase_flag == '0 && fault_n));

    // R4: leaving the retry wait happens only on timer expiry or clear
    a_r4_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && !clear && !tmr_expire) |=> drv_off);

endmodule

// File: tb/ocp_fault_ctrl_bench.sv
module ocp_fault_ctrl_bench;

    localparam int unsigned DG0 = 4;
    localparam int unsigned DG1 = 6;
    localparam int unsigned DG2 = 9;
    localparam int unsigned DG3 = 12;
    localparam int unsigned TS  = 40;
    localparam int unsigned TL  = 90;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] dg;
        logic [2:0] raw;
        logic [7:0] hi;
        logic [2:0] eflag;
        logic       edrv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'b00, 3'b001, 8'd4,  3'b001, 1'b1},
        '{2'b00, 2'b00, 3'b001, 8'd3,  3'b000, 1'b0},
        '{2'b01, 2'b01, 3'b010, 8'd6,  3'b010, 1'b1},
        '{2'b10, 2'b10, 3'b100, 8'd9,  3'b100, 1'b0},
        '{2'b11, 2'b11, 3'b001, 8'd20, 3'b000, 1'b0},
        '{2'b10, 2'b11, 3'b010, 8'd11, 3'b000, 1'b0},
        '{2'b00, 2'b11, 3'b100, 8'd12, 3'b100, 1'b1},
        '{2'b01, 2'b10, 3'b011, 8'd8,  3'b000, 1'b0},
        '{2'b10, 2'b00, 3'b101, 8'd4,  3'b101, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] oc_raw = '0;
    logic [1:0] resp_mode = '0;
    logic [1:0] dg_sel = '0;
    logic       retry_long = 1'b0;
    logic       clear = 1'b0;
    logic       drv_off;
    logic [2:0] phase_flag;
    logic       fault_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ocp_fault_ctrl #(
        .DG0_CYC(DG0), .DG1_CYC(DG1), .DG2_CYC(DG2), .DG3_CYC(DG3),
        .RETRY_SHORT_CYC(TS), .RETRY_LONG_CYC(TL)
    ) u_ocp_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .resp_mode(resp_mode),
        .dg_sel(dg_sel), .retry_long(retry_long), .clear(clear),
        .drv_off(drv_off), .phase_flag(phase_flag), .fault_n(fault_n)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        cyc(1);
        clear = 1'b0;
    endtask

    task automatic measure_off(output int cnt);
        cnt = 0;
        while (drv_off && cnt < 1000) begin
            cnt++;
            cyc(1);
        end
    endtask

    initial begin
        int n_off;
        cyc(3);
        // R11 reset state
        chk("R11 drv_off", drv_off, 0);
        chk("R11 phase_flag", phase_flag, 0);
        chk("R11 fault_n", fault_n, 1);
        rst_n = 1'b1;
        cyc(2);

        // vector table: R1 R3 R4 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            resp_mode = VECS[i].mode;
            dg_sel    = VECS[i].dg;
            oc_raw    = VECS[i].raw;
            cyc(int'(VECS[i].hi));
            oc_raw = '0;
            cyc(3);
            chk($sformatf("R1/R8 vec%0d phase_flag", i), phase_flag, VECS[i].eflag);
            chk($sformatf("R3/R6 vec%0d drv_off", i), drv_off, VECS[i].edrv);
            chk($sformatf("R9 vec%0d fault_n", i), fault_n, (VECS[i].eflag == 0) ? 1 : 0);
            pulse_clear();
            chk($sformatf("R10 vec%0d flag cleared", i), phase_flag, 0);
            chk($sformatf("R10 vec%0d drv released", i), drv_off, 0);
            cyc(2);
        end

        // R1 exact acceptance edge
        resp_mode = 2'b00; dg_sel = 2'b01; oc_raw = 3'b100;
        cyc(DG1);
        chk("R1 no effect after N edges", drv_off, 0);
        cyc(1);
        chk("R1 effect after N+1 edges", drv_off, 1);
        chk("R1 flag after N+1 edges", phase_flag, 3'b100);
        oc_raw = '0;
        // R3 latch persists
        cyc(200);
        chk("R3 still off", drv_off, 1);
        pulse_clear();
        chk("R3 released by clear", drv_off, 0);
        cyc(2);

        // R2 restart on a single low sample
        dg_sel = 2'b00;
        oc_raw = 3'b010; cyc(DG0 - 1);
        oc_raw = 3'b000; cyc(1);
        oc_raw = 3'b010; cyc(DG0 - 1);
        oc_raw = 3'b000; cyc(3);
        chk("R2 no flag", phase_flag, 0);
        chk("R2 no shutdown", drv_off, 0);

        // R4 short retry window
        resp_mode = 2'b01; retry_long = 1'b0; oc_raw = 3'b001;
        cyc(DG0 + 1);
        oc_raw = '0;
        measure_off(n_off);
        chk("R4 short off cycles", n_off, TS);
        chk("R8 flag kept after retry", phase_flag, 3'b001);
        chk("R9 fault_n after retry", fault_n, 0);
        pulse_clear();
        chk("R8 flag cleared", phase_flag, 0);
        cyc(2);

        // R5 long retry window
        retry_long = 1'b1; oc_raw = 3'b100;
        cyc(DG0 + 1);
        oc_raw = '0;
        measure_off(n_off);
        chk("R5 long off cycles", n_off, TL);
        pulse_clear();
        retry_long = 1'b0;
        cyc(2);

        // R10 clear priority while a detection is live
        resp_mode = 2'b10; oc_raw = 3'b010;
        cyc(DG0 + 2);
        chk("R6 flag in report", phase_flag, 3'b010);
        chk("R6 drive stays on", drv_off, 0);
        pulse_clear();
        chk("R10 clear beats live detection", phase_flag, 0);
        cyc(1);
        chk("R10 flag returns while held", phase_flag, 3'b010);
        oc_raw = '0;
        pulse_clear();
        cyc(2);

        // R7 ignore with long exposure
        resp_mode = 2'b11; oc_raw = 3'b111;
        cyc(30);
        chk("R7 no flag", phase_flag, 0);
        chk("R7 no shutdown", drv_off, 0);
        chk("R7 fault_n high", fault_n, 1);
        oc_raw = '0;
        cyc(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule